// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the word address for a synchronous burst memory. A burst opens when either of two start strobes is sampled high on a rising clock edge: one comes from the processor side and one from the memory controller side. The external address bus is captured at that edge and becomes the base of the burst. From then on the external bus is ignored. Each sampled advance pulse moves a small beat counter forward, and only the lowest `BW` bits of the output address depend on that counter. The upper bits always come from the captured base.

The beat counter can step through the low bits in two orders. In linear order the low bits are the base low bits plus the beat count, wrapping modulo the burst length. In interleaved order they are the base low bits XOR the beat count. An order pin picks between the two (high for linear, low for interleaved), so a pin that is tied low or pulled low gives interleaved order. A parameter can instead fix the order and ignore the pin. Bursting is optional: a new address may be started on every cycle, and there is no gap between loads.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is sampled high, the next `addr_out` is all zeros and the beat count returns to zero.
- R2: A sampled-high `start_cpu` loads `addr_in` so that `addr_out` equals it from the following cycle.
- R3: A sampled-high `start_ctl` loads `addr_in` in the same way as `start_cpu`. Both strobes high together also load.
- R4: With `order_lin` = 1 (linear), each sampled advance makes the low `BW` bits equal (base low + beats) mod 2^BW.
- R5: With `order_lin` = 0 (interleaved, the pulled-low default), the low `BW` bits equal base low XOR beats.
- R6: After 2^BW advances the beat count wraps to zero and the address returns to the loaded base.
- R7: With no strobe and no advance, `addr_out` holds its value, and changes on `addr_in` have no effect.
- R8: When a start strobe and `adv` are sampled high in the same cycle, the load wins and the beat count is zero.
- R9: A start strobe may be asserted on consecutive cycles, and each one loads its own address with no idle cycle.
- R10: Advancing never changes `addr_out` bits above the low `BW` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | AW | External address, captured on a start strobe |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance the beat counter by one |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_out | output | AW | Current burst word address |

## Verification
The hardest cases to reach are the wrap back to the base after a full burst, and the collision where a strobe and an advance land on the same edge in the middle of a burst. Reaching either one needs a burst that has already been advanced to a non-zero beat. The stimulus builds full bursts from every starting low value, in both orders. It then injects a simultaneous strobe and advance partway through a burst. A final stretch of pseudo-random strobes, advances and addresses mixes these cases with back-to-back loads, and the behavioural model is compared against the output on every clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } seq_op_e;

    typedef enum logic [1:0] {
        SRC_PIN            = 2'd0,
        SRC_FIX_LINEAR     = 2'd1,
        SRC_FIX_INTERLEAVE = 2'd2
    } order_src_e;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    // A start strobe outranks an advance on the same edge.
    function automatic seq_op_e decode_op(input logic s_a, input logic s_b, input logic step);
        if (s_a || s_b)
            return OP_LOAD;
        else if (step)
            return OP_STEP;
        return OP_HOLD;
    endfunction

    function automatic burst_order_e pick_order(input order_src_e src, input logic pin);
        case (src)
            SRC_FIX_LINEAR:     return ORD_LINEAR;
            SRC_FIX_INTERLEAVE: return ORD_INTERLEAVE;
            default:            return pin ? ORD_LINEAR : ORD_INTERLEAVE;
        endcase
    endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic    start_a,
    input  logic    start_b,
    input  logic    step,
    output seq_op_e op
);
    always_comb begin
        op = decode_op(start_a, start_b, step);
    end
endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
    import bseq_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_op_e       op,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (op == OP_LOAD)
            base_q <= addr_in;
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_op_e       op,
    output logic [BW-1:0] beat_q
);
    localparam logic [BW-1:0] ONE = BW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else begin
            case (op)
                OP_LOAD: beat_q <= '0;
                OP_STEP: beat_q <= beat_q + ONE;   // natural wrap at 2^BW
                default: beat_q <= beat_q;
            endcase
        end
    end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
#(
    parameter int         BW        = 2,
    parameter order_src_e ORDER_SRC = SRC_PIN
) (
    input  logic [BW-1:0] base_low,
    input  logic [BW-1:0] beat,
    input  logic          order_pin,
    output logic [BW-1:0] low_out
);
    logic [BW-1:0] lin_low;
    logic [BW-1:0] ilv_low;

    assign lin_low = base_low + beat;
    assign ilv_low = base_low ^ beat;

    generate
        if (ORDER_SRC == SRC_FIX_LINEAR) begin : g_fix_lin
            assign low_out = lin_low;
        end else if (ORDER_SRC == SRC_FIX_INTERLEAVE) begin : g_fix_ilv
            assign low_out = ilv_low;
        end else begin : g_pin
            burst_order_e ord;
            assign ord     = pick_order(ORDER_SRC, order_pin);
            assign low_out = (ord == ORD_LINEAR) ? lin_low : ilv_low;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int         AW        = 18,
    parameter int         BW        = 2,
    parameter order_src_e ORDER_SRC = SRC_PIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_in,
    input  logic          start_cpu,
    input  logic          start_ctl,
    input  logic          adv,
    input  logic          order_lin,
    output logic [AW-1:0] addr_out
);
    localparam int HI_W = AW - BW;

    seq_op_e       op;
    logic [AW-1:0] base_q;
    logic [BW-1:0] beat_q;
    logic [BW-1:0] low_bits;

    bseq_ctrl u_ctrl (
        .start_a (start_cpu),
        .start_b (start_ctl),
        .step    (adv),
        .op      (op)
    );

    bseq_base_reg #(.AW(AW)) u_base (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .addr_in (addr_in),
        .base_q  (base_q)
    );

    bseq_beat_ctr #(.BW(BW)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .beat_q (beat_q)
    );

    bseq_order_map #(.BW(BW), .ORDER_SRC(ORDER_SRC)) u_map (
        .base_low  (base_q[BW-1:0]),
        .beat      (beat_q),
        .order_pin (order_lin),
        .low_out   (low_bits)
    );

    generate
        if (HI_W > 0) begin : g_hi
            assign addr_out = {base_q[AW-1:BW], low_bits};
        end else begin : g_lo
            assign addr_out = low_bits;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import bseq_pkg::*;
#(
    parameter int         AW        = 18,
    parameter int         BW        = 2,
    parameter order_src_e ORDER_SRC = SRC_PIN
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr_in,
    input logic          start_cpu,
    input logic          start_ctl,
    input logic          adv,
    input logic          order_lin,
    input logic [AW-1:0] addr_out
);
    logic any_start;
    logic eff_lin;
    assign any_start = start_cpu || start_ctl;
    assign eff_lin   = (ORDER_SRC == SRC_FIX_LINEAR) ||
                       ((ORDER_SRC == SRC_PIN) && order_lin);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0));

    // R2, R3, R8, R9: any strobe loads the external address, even with adv high
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
        any_start |=> (addr_out == $past(addr_in)));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!any_start && !adv) |=> ($stable(addr_out) || !$stable(order_lin)));

    assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        (!any_start && adv) |=> (addr_out[AW-1:BW] == $past(addr_out[AW-1:BW])));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!any_start && adv && eff_lin) |=>
        (!eff_lin || (addr_out[BW-1:0] == BW'($past(addr_out[BW-1:0]) + 1'b1))));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .BW(BW), .ORDER_SRC(ORDER_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_in   (addr_in),
    .start_cpu (start_cpu),
    .start_ctl (start_ctl),
    .adv       (adv),
    .order_lin (order_lin),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int BW = 2;
    localparam int NBEAT = 1 << BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          start_cpu = 1'b0;
    logic          start_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] addr_out;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_base = 0;
    int m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.AW(AW), .BW(BW)) u_dut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .start_cpu(start_cpu),
        .start_ctl(start_ctl), .adv(adv), .order_lin(order_lin), .addr_out(addr_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_base = 0; m_cnt = 0;
        end else if (start_cpu || start_ctl) begin
            m_base = int'(addr_in); m_cnt = 0;
        end else if (adv) begin
            m_cnt = (m_cnt + 1) % NBEAT;
        end
    end

    function automatic int expect_addr();
        int lo, hi;
        hi = m_base & ~(NBEAT - 1);
        if (order_lin) lo = ((m_base & (NBEAT - 1)) + m_cnt) % NBEAT;
        else           lo = (m_base & (NBEAT - 1)) ^ m_cnt;
        return hi | lo;
    endfunction

    task automatic check_now();
        int e;
        e = expect_addr();
        checks++;
        if (int'(addr_out) !== e) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h at %0t", cur_req, addr_out, e, $time);
        end
    endtask

    task automatic cyc(input bit sc, input bit sk, input bit av, input int a);
        start_cpu = sc; start_ctl = sk; adv = av; addr_in = AW'(a);
        @(posedge clk);
        @(negedge clk);
        check_now();
    endtask

    task automatic full_burst(input bit lin, input int a, input bit use_ctl);
        order_lin = lin;
        cyc(!use_ctl, use_ctl, 1'b0, a);
        for (int k = 0; k < NBEAT; k++) cyc(1'b0, 1'b0, 1'b1, a + 7);
    endtask

    initial begin
        int seed;
        seed = 13;
        @(negedge clk);
        cyc(0, 0, 0, 'h3ffff);
        cur_req = "R1"; cyc(0, 0, 1, 0);
        rst = 1'b0;

        cur_req = "R2"; order_lin = 1; cyc(1, 0, 0, 'h12345);
        cur_req = "R3"; cyc(0, 1, 0, 'h2abcd);
        cur_req = "R3"; cyc(1, 1, 0, 'h00f0e);

        cur_req = "R4";
        for (int s = 0; s < NBEAT; s++) full_burst(1'b1, 'h1a5c0 + s, s[0]);

        cur_req = "R5";
        for (int s = 0; s < NBEAT; s++) full_burst(1'b0, 'h2f0f0 + s, !s[0]);

        cur_req = "R6"; order_lin = 1;
        cyc(1, 0, 0, 'h3fffe);
        for (int k = 0; k < NBEAT; k++) cyc(0, 0, 1, 0);
        if (addr_out !== AW'('h3fffe)) begin
            fails++; $display("FAIL R6: addr_out=%h expected=%h", addr_out, AW'('h3fffe));
        end
        checks++;

        cur_req = "R7";
        cyc(0, 0, 1, 'h11111);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 'h05a5a + k * 'h1111);

        cur_req = "R8"; order_lin = 0;
        cyc(1, 0, 0, 'h0c003);
        cyc(0, 0, 1, 0);
        cyc(0, 1, 1, 'h0c102);
        cyc(1, 0, 1, 'h0c201);

        cur_req = "R9";
        for (int k = 0; k < 6; k++) cyc(k[0], !k[0], 0, 'h10000 + k * 'h333);

        cur_req = "R10"; order_lin = 1;
        cyc(0, 1, 0, 'h3fff3);
        for (int k = 0; k < 3 * NBEAT; k++) cyc(0, 0, 1, 0);

        cur_req = "R1";
        rst = 1; cyc(0, 0, 1, 0); rst = 0;

        cur_req = "R7";
        for (int k = 0; k < 300; k++) begin
            seed = seed * 1103515245 + 12345;
            if (k % 40 == 0) order_lin = seed[20];
            cyc((seed[9:7] == 0), (seed[12:10] == 0), seed[14], seed[31:14]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: timeout actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule